// File: doc/BRIEF.md
# Reloading Down-Counter Timer Channel

This block is a single timer channel built around a 32-bit down-counter. The counter advances once per prescaled period of the input clock. The period is chosen by a code in the control register, from divide-by-4 up to divide-by-1024. When the count passes zero it is reloaded from a constant register and a sticky underflow flag is set. An interrupt line follows that flag, gated by an enable bit.

Software reaches four 32-bit registers through a word-indexed write/read port. The registers are the reload constant, the live count, the control register and a capture register. A separate run input, driven from outside the channel, pauses or resumes counting. The control fields for clock-edge choice and capture control are stored and read back, but they do not change how the channel counts.

Top module: `reload_timer_channel`

## Requirements
- R1: After a synchronous active-low reset, the reload constant and the count both read 0xFFFFFFFF. The control register and the capture register read 0, and `irq_o` is low.
- R2: `word_addr_i` selects the register: 0 is the reload constant, 1 the live count, 2 the control register and 3 the capture register (byte offsets 0x0, 0x4, 0x8 and 0xC). The capture register stores any written word and reads it back unchanged.
- R3: Control bits 2:0 select the prescale code. Codes 0, 1, 2, 3 and 4 divide the clock by 4, 16, 64, 256 and 1024. Codes 5, 6 and 7 produce no decrements, so the count holds.
- R4: While `run_i` is high, the count decrements once per prescaled period. On the period that finds the count at 0, the count reloads from the constant and the underflow flag (control bit 8) is set. A count of N therefore underflows (N+1) periods after it is loaded.
- R5: Writing the count register loads the written value and restarts the prescaler phase. The first decrement then comes exactly one full prescaled period (4·4^code clock cycles) after the write edge.
- R6: While `run_i` is low, both the count and the prescaler phase hold. When `run_i` returns high, counting resumes from the held count and the held phase.
- R7: `irq_o` is high exactly while the underflow flag is set and control bit 5 (underflow interrupt enable) is 1.
- R8: A control write with bit 8 = 0 clears the underflow flag, and a control write with bit 8 = 1 leaves the flag as it was. If an underflow occurs in the same cycle as a clearing write, the flag ends up set.
- R9: A control read returns the stored bits 7:0, the live underflow flag in bit 8, and zero in bits 31:9. Bits 31:9 of a control write are never stored; this covers the capture flag in bit 9 and the reserved bits 15:10.
- R10: Writing the reload constant does not change the live count. The next reload uses the newly written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run_i | input | 1 | Run (1) / hold (0) for the counter |
| wr_en_i | input | 1 | Register write strobe |
| word_addr_i | input | 2 | Register word index for reads and writes |
| wr_data_i | input | 32 | Write data |
| rd_data_o | output | 32 | Read data for `word_addr_i` (combinational) |
| irq_o | output | 1 | Underflow interrupt |

## Verification
The embedded assertions check the following properties on every cycle:
- The count holds when there is neither a tick nor a load.
- A direct load lands on the next cycle.
- A reload at zero takes the constant.
- The prescaler phase freezes while the channel is stopped.
- The flag rises only after a real underflow.
- An underflow beats a clearing write that arrives in the same cycle.
- The interrupt is silent while its enable bit is low.
- The upper control read bits stay zero.

Some properties cannot be seen from single-cycle relations, so only the bench scenarios can show them. These are the absolute period of each prescale code and the (N+1)-period spacing between underflows. They also include the exact clock on which the first decrement follows a count write, and the resumption of a partly elapsed phase after a pause. The bench measures each of these against cycle counts computed from the prescale code and the loaded values.

// File: rtl/rtc_pkg.sv
// Package: shared register indices and control-field positions for the
// reloading timer channel. Assumes a 32-bit register data path.
package rtc_pkg;
    typedef enum logic [1:0] {
        REG_CONST = 2'd0,
        REG_COUNT = 2'd1,
        REG_CTRL  = 2'd2,
        REG_CAPT  = 2'd3
    } reg_sel_e;

    localparam int DATA_W    = 32;
    localparam int CODE_W    = 3;   // prescale code width, bits 2:0
    localparam int IE_BIT    = 5;   // underflow interrupt enable
    localparam int KEEP_W    = 8;   // stored control bits 7:0
    localparam int FLAG_BIT  = 8;   // live underflow flag position
endpackage

// File: rtl/rtc_prescaler.sv
// Module: rtc_prescaler
// Produces a one-cycle tick every 2^(BASE_LOG2 + STEP_LOG2*code) clocks
// while run_i is high. Codes at or above NUM_CODES never tick.
// Assumes restart_i may arrive at any time and zeroes the phase.
module rtc_prescaler #(
    parameter int CODE_W    = 3,
    parameter int NUM_CODES = 5,
    parameter int BASE_LOG2 = 2,
    parameter int STEP_LOG2 = 2,
    localparam int PH_W     = BASE_LOG2 + STEP_LOG2 * (NUM_CODES - 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_i,
    input  logic              restart_i,
    input  logic [CODE_W-1:0] code_i,
    output logic              tick_o
);
    logic [PH_W-1:0] phase_q;
    logic [PH_W-1:0] lim;
    logic            valid;

    // Purpose: map the prescale code to its terminal phase value.
    always_comb begin
        lim   = '0;
        valid = 1'b0;
        for (int i = 0; i < NUM_CODES; i++) begin
            if (code_i == CODE_W'(i)) begin
                lim   = PH_W'((1 << (BASE_LOG2 + STEP_LOG2 * i)) - 1);
                valid = 1'b1;
            end
        end
    end

    assign tick_o = run_i && valid && (phase_q >= lim);

    // Purpose: advance the phase while running; zero it on a tick or a restart.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (restart_i || tick_o) begin
            phase_q <= '0;
        end else if (run_i && valid) begin
            phase_q <= phase_q + 1'b1;
        end
    end

    // R6: a stopped channel keeps its partial phase.
    p_phase_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_i && !restart_i) |=> (phase_q == $past(phase_q)));

    // R3: a running phase never passes the terminal value of its code.
    p_phase_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && valid && !restart_i && phase_q <= lim) |=> (phase_q <= $past(lim)));
endmodule

// File: rtl/rtc_counter.sv
// Module: rtc_counter
// Down-counter with direct load and reload-on-underflow. A load takes
// priority over a tick in the same cycle. underflow_o flags a tick at zero.
module rtc_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick_i,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    input  logic [W-1:0] reload_i,
    output logic [W-1:0] count_o,
    output logic         underflow_o
);
    logic [W-1:0] count_q;

    assign underflow_o = tick_i && !load_i && (count_q == '0);
    assign count_o     = count_q;

    // Purpose: load, reload at zero, or decrement on a tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '1;
        end else if (load_i) begin
            count_q <= load_val_i;
        end else if (tick_i) begin
            count_q <= (count_q == '0) ? reload_i : count_q - 1'b1;
        end
    end

    // R6: without a tick or a load the count holds.
    p_count_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !load_i) |=> (count_q == $past(count_q)));

    // R5: a direct load lands on the next cycle.
    p_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (count_q == $past(load_val_i)));

    // R4: a tick at zero reloads the constant.
    p_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !load_i && count_q == '0) |=> (count_q == $past(reload_i)));
endmodule

// File: rtl/reload_timer_channel.sv
// Module: reload_timer_channel
// One timer channel: register file, sticky underflow flag and interrupt
// gating around a prescaler and a down-counter. Reads are combinational.
// Assumes single-cycle write strobes and a 2-bit word index.
module reload_timer_channel
    import rtc_pkg::*;
#(
    parameter int CNT_W     = DATA_W,
    parameter int NUM_CODES = 5,
    parameter int BASE_LOG2 = 2,
    parameter int STEP_LOG2 = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_i,
    input  logic              wr_en_i,
    input  logic [1:0]        word_addr_i,
    input  logic [CNT_W-1:0]  wr_data_i,
    output logic [CNT_W-1:0]  rd_data_o,
    output logic              irq_o
);
    reg_sel_e           sel;
    logic [CNT_W-1:0]   const_q;
    logic [CNT_W-1:0]   capt_q;
    logic [KEEP_W-1:0]  ctrl_q;
    logic               flag_q;
    logic [CNT_W-1:0]   count;
    logic               tick;
    logic               uf;
    logic               wr_count;
    logic               wr_ctrl;
    logic               clear_wr;

    assign sel      = reg_sel_e'(word_addr_i);
    assign wr_count = wr_en_i && (sel == REG_COUNT);
    assign wr_ctrl  = wr_en_i && (sel == REG_CTRL);
    assign clear_wr = wr_ctrl && !wr_data_i[FLAG_BIT];

    rtc_prescaler #(
        .CODE_W    (CODE_W),
        .NUM_CODES (NUM_CODES),
        .BASE_LOG2 (BASE_LOG2),
        .STEP_LOG2 (STEP_LOG2)
    ) u_presc (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (run_i),
        .restart_i (wr_count),
        .code_i    (ctrl_q[CODE_W-1:0]),
        .tick_o    (tick)
    );

    rtc_counter #(
        .W (CNT_W)
    ) u_cnt (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_i      (tick),
        .load_i      (wr_count),
        .load_val_i  (wr_data_i),
        .reload_i    (const_q),
        .count_o     (count),
        .underflow_o (uf)
    );

    // Purpose: store the constant, capture and kept control bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            const_q <= '1;
            capt_q  <= '0;
            ctrl_q  <= '0;
        end else if (wr_en_i) begin
            case (sel)
                REG_CONST: const_q <= wr_data_i;
                REG_CAPT:  capt_q  <= wr_data_i;
                REG_CTRL:  ctrl_q  <= wr_data_i[KEEP_W-1:0];
                default:   ;
            endcase
        end
    end

    // Purpose: sticky underflow flag; a new underflow beats a clearing write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (uf) begin
            flag_q <= 1'b1;
        end else if (clear_wr) begin
            flag_q <= 1'b0;
        end
    end

    assign irq_o = flag_q && ctrl_q[IE_BIT];

    // Purpose: read multiplexer with the live flag merged into the control word.
    always_comb begin
        case (sel)
            REG_CONST: rd_data_o = const_q;
            REG_COUNT: rd_data_o = count;
            REG_CTRL:  rd_data_o = {{(CNT_W-KEEP_W-1){1'b0}}, flag_q, ctrl_q};
            default:   rd_data_o = capt_q;
        endcase
    end

    // R4: the flag rises only after a real underflow.
    p_flag_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q) |-> $past(uf));

    // R8: an underflow in the cycle of a clearing write leaves the flag set.
    p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (uf && clear_wr) |=> flag_q);

    // R7: no interrupt while the enable bit is low.
    p_irq_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_q[IE_BIT] |-> !irq_o);

    // R9: upper control read bits are always zero.
    p_ctrl_upper_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == REG_CTRL) |-> (rd_data_o[CNT_W-1:FLAG_BIT+1] == '0));
endmodule

// File: tb/reload_timer_channel_test.sv
// Bench: drives inputs and samples outputs at the falling edge. Expected
// values come from the prescale arithmetic 4*4^code and the loaded counts.
module reload_timer_channel_test;
    localparam int CLK_PERIOD = 10;
    localparam logic [1:0] A_CONST = 2'd0;
    localparam logic [1:0] A_COUNT = 2'd1;
    localparam logic [1:0] A_CTRL  = 2'd2;
    localparam logic [1:0] A_CAPT  = 2'd3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run = 1'b0;
    logic        we = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;
    int          checks = 0;
    int          failures = 0;
    bit          done = 1'b0;

    reload_timer_channel uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .run_i       (run),
        .wr_en_i     (we),
        .word_addr_i (addr),
        .wr_data_i   (wdata),
        .rd_data_o   (rdata),
        .irq_o       (irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    // Called at a falling edge; the write lands on the next rising edge.
    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    initial begin
        logic [31:0] v;
        int k;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset values
        rd(A_CONST, v); chk("R1 const", v, 32'hFFFF_FFFF);
        rd(A_COUNT, v); chk("R1 count", v, 32'hFFFF_FFFF);
        rd(A_CTRL, v);  chk("R1 ctrl", v, 32'h0);
        rd(A_CAPT, v);  chk("R1 capture", v, 32'h0);
        chk("R1 irq", {31'b0, irq}, 32'h0);

        // R2 capture storage
        wr(A_CAPT, 32'hCAFE_0123);
        rd(A_CAPT, v); chk("R2 capture readback", v, 32'hCAFE_0123);

        // R3/R4/R5/R10 sweep over codes 0..4 and counts 0..2
        run = 1'b1;
        for (int c = 0; c < 5; c++) begin
            for (int n = 0; n < 3; n++) begin
                int div;
                div = 4 << (2 * c);
                wr(A_CONST, 32'(n + 1));
                wr(A_CTRL, 32'h20 | 32'(c));
                wr(A_COUNT, 32'(n));
                k = 0;
                while (!irq && k < 5000) begin @(negedge clk); k++; end
                chk($sformatf("R3 R4 R5 first underflow code=%0d n=%0d", c, n), 32'(k), 32'((n + 1) * div));
                rd(A_COUNT, v);
                chk("R10 reload takes constant", v, 32'(n + 1));
                wr(A_CTRL, 32'h20 | 32'(c));
                k = 1;
                while (!irq && k < 8000) begin @(negedge clk); k++; end
                chk($sformatf("R4 reload period code=%0d n=%0d", c, n), 32'(k), 32'((n + 2) * div));
            end
        end

        // R6 hold while stopped, resume from held count and phase
        run = 1'b0;
        wr(A_CTRL, 32'h20);
        wr(A_COUNT, 32'd9);
        repeat (50) @(negedge clk);
        rd(A_COUNT, v); chk("R6 hold while stopped", v, 32'd9);
        run = 1'b1;
        repeat (3) @(negedge clk);
        rd(A_COUNT, v); chk("R5 no decrement before full period", v, 32'd9);
        @(negedge clk);
        rd(A_COUNT, v); chk("R5 decrement after one period", v, 32'd8);
        repeat (2) @(negedge clk);
        run = 1'b0;
        repeat (20) @(negedge clk);
        run = 1'b1;
        @(negedge clk);
        rd(A_COUNT, v); chk("R6 partial phase kept", v, 32'd8);
        @(negedge clk);
        rd(A_COUNT, v); chk("R6 resume decrement", v, 32'd7);

        // R3 reserved codes halt counting
        wr(A_CTRL, 32'h5);
        wr(A_COUNT, 32'd3);
        repeat (2100) @(negedge clk);
        rd(A_COUNT, v); chk("R3 code 5 no count", v, 32'd3);
        wr(A_CTRL, 32'h7);
        repeat (2100) @(negedge clk);
        rd(A_COUNT, v); chk("R3 code 7 no count", v, 32'd3);

        // R9 upper write bits not stored
        wr(A_CTRL, 32'hFFFF_FEFF);
        rd(A_CTRL, v); chk("R9 ctrl masks upper bits", v, 32'h0000_00FF);

        // R10 constant write leaves count
        wr(A_COUNT, 32'h55);
        wr(A_CONST, 32'hABC);
        rd(A_COUNT, v); chk("R10 count unchanged by constant write", v, 32'h55);

        // R7/R8 flag rules
        wr(A_CONST, 32'd3);
        wr(A_CTRL, 32'h20);
        wr(A_COUNT, 32'd0);
        repeat (4) @(negedge clk);
        chk("R7 irq with flag and enable", {31'b0, irq}, 32'h1);
        wr(A_CTRL, 32'h107);
        rd(A_CTRL, v); chk("R8 writing one keeps flag", v, 32'h107);
        chk("R7 irq low with enable off", {31'b0, irq}, 32'h0);
        wr(A_CTRL, 32'h027);
        rd(A_CTRL, v); chk("R8 writing zero clears flag", v, 32'h027);
        chk("R7 irq low after clear", {31'b0, irq}, 32'h0);

        // R8 underflow and clearing write in the same cycle
        wr(A_CTRL, 32'h20);
        wr(A_COUNT, 32'd0);
        repeat (3) @(negedge clk);
        wr(A_CTRL, 32'h27);
        rd(A_CTRL, v); chk("R8 underflow beats clear", v, 32'h127);
        chk("R7 irq after collision", {31'b0, irq}, 32'h1);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule